// File: doc/BRIEF.md
# Serial Cyclic Code Syndrome Checker

This block checks a 7-bit received word from a cyclic code whose generator is G(p) = 1 + p + p^3. The word arrives serially, one coefficient per cycle in which `bit_valid` is high. A feedback shift register divides the received polynomial by G(p) as the bits come in. When the bit marked by `bit_last` has been taken, the block presents the 3-bit remainder as the syndrome, raises an error flag if that remainder is nonzero, and pulses a done strobe for one cycle.

A received word R(p) is the sum of a transmitted codeword and an error pattern. Every codeword is a multiple of G(p), so the syndrome depends only on the error pattern. An all-zero syndrome means no detectable error. For a single flipped bit at power p^i, the syndrome is p^i mod G(p). The seven single-bit cases give seven distinct nonzero values, so a later stage could use the syndrome to locate the error. This block only computes and reports it.

The division register clears itself on the cycle that takes the last bit. A new word can therefore start on the very next cycle, with no idle gap.

Top module: `syn_check`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears `syn_out`, `syn_err` and `syn_done` to 0 at that edge.
- R2: Bits enter highest power first. The first valid bit of a word is the coefficient of p^6, and the seventh is the coefficient of p^0.
- R3: After the last bit, `syn_out` holds R(p) mod (1 + p + p^3). Bit i of `syn_out` is the coefficient of p^i.
- R4: Every word that is a multiple of G(p) gives `syn_out` = 0 and `syn_err` = 0. There are 16 such words.
- R5: A word with only bit p^i set (i = 0..6) gives `syn_out` = p^i mod G(p). The seven values are nonzero and pairwise distinct. For example, p^6 gives 3'b101.
- R6: `syn_done` is high for exactly one cycle. That cycle is the one after a cycle with both `bit_valid` and `bit_last` high. `syn_done` is low at every other time.
- R7: `syn_err` is high exactly when `syn_out` is nonzero.
- R8: A cycle with `bit_valid` low leaves the division state unchanged, whatever the value on `bit_in`. Idle gaps inside a word do not change its syndrome.
- R9: The division register is cleared by the cycle that takes the last bit. A word starting on the next cycle is divided from zero.
- R10: `syn_out` and `syn_err` keep their value until the next done strobe.
- R11: `bit_last` has no effect when `bit_valid` is low. No strobe follows, and the word in progress continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Received coefficient, highest power first |
| bit_valid | input | 1 | `bit_in` is taken in this cycle |
| bit_last | input | 1 | This valid bit is the final one of the word |
| syn_out | output | 3 | Remainder of the word divided by G(p), bit i = coefficient of p^i |
| syn_err | output | 1 | Syndrome is nonzero |
| syn_done | output | 1 | One-cycle strobe: a new syndrome is presented |

## Verification
The syndrome, the error flag and the done strobe are all due one clock edge after the cycle that carries `bit_last` with `bit_valid`. Nothing else in the block has any latency. The bench drives its inputs at the falling edge and updates its reference model at the same moment. It then compares all three outputs at the next falling edge, which is exactly one rising edge later. This compare happens on every cycle, so the hold behaviour and the absence of spurious strobes are checked continuously. The scenario checks read the outputs in the done cycle and compare them against remainders that the bench computes by long division.

// File: rtl/syn_pkg.sv
// Package: shared constants for the serial cyclic-code syndrome checker.
// Assumes a binary field (mod-2 arithmetic) and a generator whose top
// coefficient is 1.
package syn_pkg;
    // Degree of the generator, equal to the number of check bits.
    localparam int SYN_DEG = 3;
    // Generator coefficients, bit j = coefficient of p^j: 1 + p + p^3.
    localparam logic [SYN_DEG:0] SYN_GEN = 4'b1011;
    // Length of a code word in bits.
    localparam int CODE_LEN = 7;

    typedef logic [SYN_DEG-1:0] syn_t;
endpackage

// File: rtl/syn_div_core.sv
// Module: syn_div_core
// Divides a serially supplied polynomial, highest power first, by the
// generator GEN. It keeps the running remainder and exposes the value the
// remainder takes after the current bit (rem_next).
// Assumes GEN[DEG] == 1. The remainder clears when clr is asserted.
module syn_div_core #(
    parameter int             DEG = 3,
    parameter logic [DEG:0]   GEN = 4'b1011
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           din,
    input  logic           clr,
    output logic [DEG-1:0] rem_next
);
    logic [DEG-1:0] rem_q;
    logic           fb;

    // Feedback: the coefficient that overflows out of the remainder.
    assign fb = rem_q[DEG-1];

    // One tap per remainder bit: shift up and subtract the generator when fb is set.
    for (genvar j = 0; j < DEG; j++) begin : g_tap
        logic shifted;
        if (j == 0) begin : g_low
            assign shifted = din;
        end else begin : g_up
            assign shifted = rem_q[j-1];
        end
        if (GEN[j]) begin : g_fb
            assign rem_next[j] = shifted ^ fb;
        end else begin : g_nofb
            assign rem_next[j] = shifted;
        end
    end

    // Remainder register: clears on reset or end of word, else advances on valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rem_q <= '0;
        end else if (shift_en) begin
            rem_q <= rem_next;
        end
    end
endmodule

// File: rtl/syn_result_stage.sv
// Module: syn_result_stage
// Captures the final remainder at the end of a word. It holds the remainder
// as the syndrome, derives the error flag and produces a one-cycle done strobe.
// Assumes commit is high for exactly the cycle that takes the last bit.
module syn_result_stage #(
    parameter int DEG = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           commit,
    input  logic [DEG-1:0] rem_in,
    output logic [DEG-1:0] syn,
    output logic           err,
    output logic           done
);
    logic [DEG-1:0] syn_q;
    logic           err_q;
    logic           done_q;

    // Syndrome and flag registers: load on commit, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn_q <= '0;
            err_q <= 1'b0;
        end else if (commit) begin
            syn_q <= rem_in;
            err_q <= |rem_in;
        end
    end

    // Done strobe: high for the single cycle after a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= commit;
        end
    end

    assign syn  = syn_q;
    assign err  = err_q;
    assign done = done_q;
endmodule

// File: rtl/syn_check.sv
// Module: syn_check (top)
// Serial syndrome checker for a 7-bit cyclic code with generator 1+p+p^3.
// Bits arrive highest power first when bit_valid is high, and bit_last marks
// the final bit. One cycle later the remainder is presented with an error
// flag and a done strobe. The divider clears itself on the last bit, so
// words may follow back to back.
module syn_check
    import syn_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_in,
    input  logic               bit_valid,
    input  logic               bit_last,
    output logic [SYN_DEG-1:0] syn_out,
    output logic               syn_err,
    output logic               syn_done
);
    logic   commit;
    syn_t   rem_next;

    // End of word: a valid bit that carries the last marker.
    assign commit = bit_valid & bit_last;

    syn_div_core #(
        .DEG (SYN_DEG),
        .GEN (SYN_GEN)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_valid),
        .din      (bit_in),
        .clr      (commit),
        .rem_next (rem_next)
    );

    syn_result_stage #(
        .DEG (SYN_DEG)
    ) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .rem_in (rem_next),
        .syn    (syn_out),
        .err    (syn_err),
        .done   (syn_done)
    );
endmodule

// File: rtl/syn_check_sva.sv
// Module: syn_check_sva
// Checker bound to syn_check. It checks the strobe timing, the hold
// behaviour, the error flag timing and the reset state at the ports.
module syn_check_sva #(
    parameter int DEG = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bit_valid,
    input logic           bit_last,
    input logic [DEG-1:0] syn_out,
    input logic           syn_err,
    input logic           syn_done
);
    // R1: a reset edge leaves all outputs cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (syn_out == '0 && !syn_err && !syn_done));

    // R6: a last valid bit is followed by the strobe.
    a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && bit_last) |=> syn_done);

    // R6, R11: no strobe without a last valid bit.
    a_r6_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_valid && bit_last) |=> !syn_done);

    // R10: the syndrome holds between strobes.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_valid && bit_last) |=> ($stable(syn_out) && $stable(syn_err)));

    // R7: the error flag only rises together with a new syndrome.
    a_r7_err_timing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_err) |-> (syn_done && syn_out != '0));
endmodule

bind syn_check syn_check_sva #(.DEG(syn_pkg::SYN_DEG)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .bit_last  (bit_last),
    .syn_out   (syn_out),
    .syn_err   (syn_err),
    .syn_done  (syn_done)
);

// File: tb/sim_syn_check.sv
// Bench for syn_check. The behavioural reference model is a queue of
// received bits plus long division, and it is compared at every falling edge.
module sim_syn_check;
    localparam int CLK_PERIOD = 10;
    localparam int WLEN = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_last = 1'b0;
    logic [2:0] syn_out;
    logic       syn_err;
    logic       syn_done;

    int total = 0;
    int bad = 0;
    int exp_syn = 0;
    int exp_done = 0;
    int rx_bits[$];
    int single_syn[WLEN];

    always #(CLK_PERIOD/2) clk = ~clk;

    syn_check u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .bit_last  (bit_last),
        .syn_out   (syn_out),
        .syn_err   (syn_err),
        .syn_done  (syn_done)
    );

    // Long division of v (len bits) by 1 + p + p^3; returns the remainder.
    function automatic int gf_mod(int v, int len);
        int r = v;
        for (int d = len - 1; d >= 3; d--) begin
            if ((r >> d) & 1) r = r ^ (32'b1011 << (d - 3));
        end
        return r;
    endfunction

    // Carry-less product of two small polynomials.
    function automatic int cl_mul(int a, int b);
        int r = 0;
        for (int i = 0; i < 8; i++) begin
            if ((b >> i) & 1) r = r ^ (a << i);
        end
        return r;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: compare the outputs of the previous edge, then drive and predict.
    task automatic step(bit v, bit b, bit l);
        @(negedge clk);
        check("R6 done strobe", int'(syn_done), exp_done);
        check("R3 syndrome", int'(syn_out), exp_syn);
        check("R7 error flag", int'(syn_err), int'(exp_syn != 0));
        bit_valid = v;
        bit_in    = b;
        bit_last  = l;
        exp_done  = 0;
        if (v) begin
            rx_bits.push_back(int'(b));
            if (l) begin
                int w = 0;
                foreach (rx_bits[k]) w = (w << 1) | rx_bits[k];
                exp_syn  = gf_mod(w, rx_bits.size());
                exp_done = 1;
                rx_bits.delete();
            end
        end
    endtask

    // Send a 7-bit word highest power first; with gaps, idle cycles carry noise and stray last.
    task automatic send_word(int w, bit gaps);
        for (int i = WLEN - 1; i >= 0; i--) begin
            step(1'b1, bit'((w >> i) & 1), i == 0);
            if (gaps && i != 0) step(1'b0, bit'(i & 1), bit'(i == 3));
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset syn_out", int'(syn_out), 0);
        check("R1 reset syn_err", int'(syn_err), 0);
        check("R1 reset syn_done", int'(syn_done), 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0);

        // R2: a single bit sent first is the p^6 coefficient (p^6 mod G = 101)
        send_word(32'b1000000, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R2 highest power first", int'(syn_out), 5);
        check("R2 strobe", int'(syn_done), 1);

        // R4: every codeword M(p)*G(p) gives a zero syndrome
        for (int m = 0; m < 16; m++) begin
            send_word(cl_mul(m, 32'b1011), 1'b0);
            step(1'b0, 1'b0, 1'b0);
            check("R4 codeword syndrome", int'(syn_out), 0);
            check("R4 codeword error flag", int'(syn_err), 0);
        end

        // R5: single-bit errors on a codeword give p^i mod G
        for (int i = 0; i < WLEN; i++) begin
            send_word(cl_mul(32'b1101, 32'b1011) ^ (1 << i), 1'b0);
            step(1'b0, 1'b1, 1'b0);
            single_syn[i] = int'(syn_out);
            check("R5 single error syndrome", int'(syn_out), gf_mod(1 << i, WLEN));
            check("R7 single error flag", int'(syn_err), 1);
        end
        for (int i = 0; i < WLEN; i++) begin
            check("R5 nonzero", int'(single_syn[i] != 0), 1);
            for (int j = i + 1; j < WLEN; j++)
                check("R5 distinct", int'(single_syn[i] != single_syn[j]), 1);
        end

        // R10: outputs hold over idle cycles
        for (int k = 0; k < 5; k++) begin
            step(1'b0, bit'(k & 1), 1'b0);
            check("R10 hold syndrome", int'(syn_out), single_syn[WLEN-1]);
        end

        // R8, R11: gaps with noise and a stray last do not disturb the word
        send_word(32'b1011001, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        check("R8 gapped word syndrome", int'(syn_out), gf_mod(32'b1011001, WLEN));
        check("R11 strobe only at real end", int'(syn_done), 1);

        // R9: back-to-back words, each divided from zero
        for (int w = 1; w < 128; w += 13) begin
            send_word(w, 1'b0);
        end
        send_word(32'b0000011, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R9 back-to-back syndrome", int'(syn_out), 3);

        // R1: reset mid-word clears outputs
        step(1'b1, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        bit_valid = 1'b0;
        rx_bits.delete();
        exp_syn = 0;
        exp_done = 0;
        @(negedge clk);
        check("R1 reset clears syndrome", int'(syn_out), 0);
        rst_n = 1'b1;
        send_word(32'b0000001, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R9 fresh word after reset", int'(syn_out), 1);
        step(1'b0, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule